// File: doc/BRIEF.md
# Misaligned Load Split-and-Merge Unit

This unit sits between a load pipeline and a memory read port that only serves naturally aligned accesses. The pipeline hands it a byte address and a power-of-two access size. The unit returns the loaded value with byte 0 in the least significant lane, whatever the alignment of the address.

When the address is a multiple of the access size, the unit makes a single aligned read. Otherwise it makes two reads. The first read covers the aligned block that holds the first requested byte. The second read covers the block directly after it. From each read the unit keeps only the bytes that belong to the result and shifts them into position. The low part goes into the result register, and the high part is then OR-ed into that same register, so no separate merge step is needed.

The request and response sides use valid/ready handshakes. Only one load is in flight at a time. Memory data arrives one cycle after a read is issued.

Top module: `misaligned_load_unit`

## Requirements
- R1: When the request address is a multiple of the access size, exactly one memory read is issued. That read uses the request address, and `mem_rd_size` carries the request's size code.
- R2: When the address is not a multiple of the size S, two reads are issued in consecutive cycles. The first is at the address with its low log2(S) bits cleared. The second is at the first address plus S, taken modulo 2^ADDR_W.
- R3: Size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. Memory is little-endian: a read at address X returns byte X+k in data lane k, for k < S. The response carries byte addr+k in lane k for every k < S, and all lanes at or above S are zero.
- R4: Read-data lanes that do not contribute to the result have no effect on `rsp_data`. These are the lanes at or above S in every read, the lanes below the offset in the low read, and the lanes at or above the offset in the high read.
- R5: A size code of 0 always produces exactly one read, at any address.
- R6: `rsp_valid` rises exactly two cycles after the cycle in which the last memory read of the load was issued.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` holds its value.
- R8: `req_ready` is high only while the unit is idle. It drops in the cycle after a request is accepted and comes back in the cycle after the response handshake.
- R9: A synchronous active-high reset abandons any load in flight. After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | SIZE_W | log2 of the access size in bytes |
| mem_rd_en | output | 1 | Aligned read issued this cycle |
| mem_rd_addr | output | ADDR_W | Aligned read address |
| mem_rd_size | output | SIZE_W | Size code of the aligned read |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after mem_rd_en |
| rsp_valid | output | 1 | Assembled result available |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_data | output | DATA_W | Assembled little-endian result, zero above the size |

## Verification
The in-RTL properties check the cycle-level protocol on every cycle:
- the second read address steps up by the access size;
- every read address is aligned;
- single-read behaviour holds for aligned and byte-sized loads;
- the response arrives two cycles after the last read;
- the response is held under back-pressure;
- `req_ready` drops after acceptance;
- result lanes above the size are zero.

Whether the assembled bytes actually match memory contents can only be shown by the bench scenarios. The bench sweeps every size and offset against a byte-array model, and that model fills the non-contributing lanes with garbage. Wraparound of the second address and reset in the middle of a load are also covered only by directed bench cases.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_LO,
        ST_ISSUE_HI,
        ST_FINISH,
        ST_RESP
    } mlu_state_e;

    function automatic int lanes_of(input int data_w);
        return data_w / BYTE_W;
    endfunction

    function automatic int count_width(input int lanes);
        return $clog2(lanes + 1);
    endfunction

    function automatic int size_code_width(input int lanes);
        return $clog2($clog2(lanes) + 1);
    endfunction

endpackage

// File: rtl/mlu_addr_split.sv
module mlu_addr_split #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2,
    parameter int CNT_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size_log2,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [CNT_W-1:0]  nbytes,
    output logic [CNT_W-1:0]  offset,
    output logic              split
);
    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        nbytes   = CNT_W'(1) << size_log2;
        low_mask = ADDR_W'(nbytes) - ADDR_W'(1);
        lo_addr  = addr & ~low_mask;
        hi_addr  = lo_addr + ADDR_W'(nbytes);
        offset   = CNT_W'(addr & low_mask);
        split    = (offset != '0);
    end

endmodule

// File: rtl/mlu_part_align.sv
module mlu_part_align #(
    parameter int DATA_W    = 64,
    parameter int CNT_W     = 4,
    parameter bit HIGH_PART = 1'b0
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic [CNT_W-1:0]  offset,
    output logic [DATA_W-1:0] part
);
    import mlu_pkg::*;

    localparam int NB   = lanes_of(DATA_W);
    localparam int SH_W = CNT_W + 3;

    logic [CNT_W-1:0]  keep_cnt;
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] kept;
    logic [SH_W-1:0]   shamt;

    generate
        if (HIGH_PART) begin : g_high
            // high block contributes its lanes below the offset, placed on top
            always_comb begin
                keep_cnt = offset;
                shamt    = {nbytes - offset, 3'b000};
            end
        end else begin : g_low
            // low block contributes lanes offset..size-1, moved down to lane 0
            always_comb begin
                keep_cnt = nbytes;
                shamt    = {offset, 3'b000};
            end
        end
    endgenerate

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            keep[b*BYTE_W +: BYTE_W] = (CNT_W'(b) < keep_cnt) ? '1 : '0;
        end
        kept = rdata & keep;
        if (HIGH_PART) part = kept << shamt;
        else           part = kept >> shamt;
    end

endmodule

// File: rtl/misaligned_load_unit.sv
module misaligned_load_unit
    import mlu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SIZE_W = size_code_width(lanes_of(DATA_W))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [SIZE_W-1:0] mem_rd_size,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int NB    = lanes_of(DATA_W);
    localparam int CNT_W = count_width(NB);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
    } load_req_t;

    mlu_state_e        state_q, state_d;
    load_req_t         req_q;
    logic [DATA_W-1:0] result_q;

    logic [ADDR_W-1:0] lo_addr, hi_addr;
    logic [CNT_W-1:0]  nbytes, offset;
    logic              split;
    logic [DATA_W-1:0] lo_part, hi_part;

    mlu_addr_split #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) split_i (
        .addr      (req_q.addr),
        .size_log2 (req_q.size),
        .lo_addr   (lo_addr),
        .hi_addr   (hi_addr),
        .nbytes    (nbytes),
        .offset    (offset),
        .split     (split)
    );

    mlu_part_align #(.DATA_W(DATA_W), .CNT_W(CNT_W), .HIGH_PART(1'b0)) lo_align_i (
        .rdata  (mem_rd_data),
        .nbytes (nbytes),
        .offset (offset),
        .part   (lo_part)
    );

    mlu_part_align #(.DATA_W(DATA_W), .CNT_W(CNT_W), .HIGH_PART(1'b1)) hi_align_i (
        .rdata  (mem_rd_data),
        .nbytes (nbytes),
        .offset (offset),
        .part   (hi_part)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_ISSUE_LO;
            ST_ISSUE_LO: state_d = split ? ST_ISSUE_HI : ST_FINISH;
            ST_ISSUE_HI: state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_RESP;
            ST_RESP:     if (rsp_ready) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid && req_ready) begin
                req_q.addr <= req_addr;
                req_q.size <= req_size;
            end
            // low part lands while the high read is in flight; high part ORs onto it
            if (state_q == ST_ISSUE_HI) begin
                result_q <= lo_part;
            end else if (state_q == ST_FINISH) begin
                result_q <= split ? (result_q | hi_part) : lo_part;
            end
        end
    end

    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_rd_en   = (state_q == ST_ISSUE_LO) || (state_q == ST_ISSUE_HI);
        mem_rd_addr = (state_q == ST_ISSUE_HI) ? hi_addr : lo_addr;
        mem_rd_size = req_q.size;
        rsp_valid   = (state_q == ST_RESP);
        rsp_data    = result_q;
    end

    logic [DATA_W-1:0] rsp_keep;
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            rsp_keep[b*BYTE_W +: BYTE_W] = (CNT_W'(b) < nbytes) ? '1 : '0;
        end
    end

    AST_ALIGNED_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && state_q == ST_ISSUE_LO && offset == '0) |=> !mem_rd_en); // R1
    AST_HI_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && state_q == ST_ISSUE_HI) |-> mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(nbytes)); // R2
    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_rd_addr & (ADDR_W'(nbytes) - ADDR_W'(1))) == '0); // R2
    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_data & ~rsp_keep) == '0); // R3
    AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && mem_rd_size == '0) |=> !mem_rd_en); // R5
    AST_RSP_DELAY: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> ($past(mem_rd_en, 2) && !$past(mem_rd_en))); // R6
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R8

endmodule

// File: tb/misaligned_load_unit_tb_top.sv
module misaligned_load_unit_tb_top;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int NB     = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_size;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [1:0]        mem_rd_size;
    logic [DATA_W-1:0] mem_rd_data;
    logic              rsp_valid;
    logic              rsp_ready;
    logic [DATA_W-1:0] rsp_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] mem [0:255];

    always #2 clk = ~clk;

    misaligned_load_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_size(mem_rd_size), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    // aligned memory model: valid lanes from the byte array, garbage above the size
    always @(posedge clk) begin
        if (mem_rd_en) begin
            for (int k = 0; k < NB; k++) begin
                mem_rd_data[k*8 +: 8] <= (k < (1 << mem_rd_size))
                    ? mem[mem_rd_addr[7:0] + 8'(k)] : (8'hA5 ^ 8'(k * 17));
            end
        end
    end

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  szl;
        logic [31:0] exp_lo;
        logic [1:0]  exp_reads;
        logic [3:0]  stall;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0040, 2'd3, 32'h0000_0040, 2'd1, 4'd0},
        '{32'h0000_0041, 2'd3, 32'h0000_0040, 2'd2, 4'd2},
        '{32'h0000_0047, 2'd3, 32'h0000_0040, 2'd2, 4'd0},
        '{32'h0000_007F, 2'd0, 32'h0000_007F, 2'd1, 4'd1},
        '{32'h0000_0033, 2'd1, 32'h0000_0032, 2'd2, 4'd0},
        '{32'h0000_0036, 2'd2, 32'h0000_0034, 2'd2, 4'd3},
        '{32'h0000_0034, 2'd2, 32'h0000_0034, 2'd1, 4'd0},
        '{32'h0000_00FD, 2'd2, 32'h0000_00FC, 2'd2, 4'd0},
        '{32'h1234_5679, 2'd1, 32'h1234_5678, 2'd2, 4'd1},
        '{32'hFFFF_FFFF, 2'd0, 32'hFFFF_FFFF, 2'd1, 4'd0},
        '{32'hFFFF_FFFE, 2'd3, 32'hFFFF_FFF8, 2'd2, 4'd2}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_load(input logic [31:0] addr, input logic [1:0] szl);
        logic [63:0] r = '0;
        for (int k = 0; k < (1 << szl); k++) r[k*8 +: 8] = mem[addr[7:0] + 8'(k)];
        return r;
    endfunction

    task automatic run_load(input logic [31:0] addr, input logic [1:0] szl,
                            input logic [31:0] exp_lo, input int exp_reads, input int stall);
        logic [31:0] rd_addr [4];
        int n_rd = 0;
        int last = -10;
        int c = 0;
        bit seen = 1'b0;
        logic [63:0] held;
        int guard = 0;
        while (!req_ready && guard < 20) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_addr = addr; req_size = szl;
        @(negedge clk);
        req_valid = 1'b0;
        while (!seen && c < 16) begin
            if (mem_rd_en) begin
                if (n_rd < 4) rd_addr[n_rd] = mem_rd_addr;
                n_rd++;
                last = c;
            end
            if (rsp_valid) seen = 1'b1;
            else begin @(negedge clk); c++; end
        end
        check(seen, "R6 response seen", 64'(seen), 64'd1);
        check(n_rd == exp_reads, (exp_reads == 1) ? "R1 R5 read count" : "R2 read count",
              64'(n_rd), 64'(exp_reads));
        if (n_rd >= 1)
            check(rd_addr[0] == exp_lo, "R1 R2 first read address", 64'(rd_addr[0]), 64'(exp_lo));
        if (exp_reads == 2 && n_rd >= 2)
            check(rd_addr[1] == exp_lo + (32'd1 << szl), "R2 second read address",
                  64'(rd_addr[1]), 64'(exp_lo + (32'd1 << szl)));
        check(c - last == 2, "R6 latency after last read", 64'(c - last), 64'd2);
        check(rsp_data == ref_load(addr, szl), "R3 R4 assembled data", rsp_data, ref_load(addr, szl));
        check(!req_ready, "R8 busy while responding", 64'(req_ready), 64'd0);
        held = rsp_data;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check(rsp_valid && rsp_data == held, "R7 hold under back-pressure", rsp_data, held);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready, "R8 idle after handshake",
              {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
        mem_rd_data = '0;
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0; rsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_rd_en, "R9 reset state",
              {61'd0, req_ready, rsp_valid, mem_rd_en}, 64'd4);

        for (int v = 0; v < NVEC; v++)
            run_load(VECS[v].addr, VECS[v].szl, VECS[v].exp_lo, int'(VECS[v].exp_reads), int'(VECS[v].stall));

        // every size and offset at two bases
        for (int base = 16; base <= 144; base += 128) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int off = 0; off < (1 << sz); off++) begin
                    run_load(32'(base + off), 2'(sz), 32'(base), (off != 0) ? 2 : 1, off % 3);
                end
            end
        end

        // reset in the middle of a misaligned load
        req_valid = 1'b1; req_addr = 32'h0000_0023; req_size = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(req_ready && !rsp_valid && !mem_rd_en, "R9 reset abandons load",
              {61'd0, req_ready, rsp_valid, mem_rd_en}, 64'd4);
        repeat (4) @(negedge clk);
        check(!rsp_valid && !mem_rd_en, "R9 no stale response", {62'd0, rsp_valid, mem_rd_en}, 64'd0);
        run_load(32'h0000_0023, 2'd3, 32'h0000_0020, 2, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule